// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the register file that a processor sees when it programs a four-channel DMA controller. It decodes a 4-bit register offset with separate read and write strobes and a byte-wide data bus. Each channel has 16-bit base and current address registers, 16-bit base and current count registers, a 6-bit mode field, a mask bit and a software request bit. The 16-bit registers are reached one byte at a time through a shared byte pointer.

The transfer engine behind it reads the channel state from flat output vectors. It returns terminal-count pulses, live pending-request levels and a temporary-register load. Several reads have side effects:
- reading status clears the terminal-count flags;
- reading the mode offset advances a channel counter;
- two other offsets set the byte pointer or zero that counter when read.

Read data is combinational from the registered state in the strobe cycle. All updates take effect at the next rising clock edge.

Top module: `dmac_regfile`

## Requirements
- R1: Offsets 0 to 7 reach channel registers. The channel is offset bits 2:1. Offset bit 0 clear selects the address register and set selects the count register. A write updates the selected byte of both the base and the current register. A read returns the byte of the current register.
- R2: The byte pointer selects bits 7:0 when clear and bits 15:8 when set. It inverts after every read or write of offsets 0 to 7, and it is clear after reset.
- R3: A read of offset 8 returns {pend_in, terminal-count flags}. A tc_in bit sets its flag, and the flag stays set until the next status read. A status read clears all flags, except that a tc_in bit in that same cycle leaves its flag set afterwards. That new flag is not part of the current read.
- R4: A write to offset 9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of channel data[1:0]. A write to offset 10 does the same for that channel's mask bit.
- R5: A write to offset 11 stores data[7:2] as the mode of channel data[1:0]. Mode bits 1:0 are the transfer type, bit 2 is auto-initialise, bit 3 is address decrement, and bits 5:4 are the service mode.
- R6: A write to offset 12 clears the byte pointer, and a read of offset 12 sets it.
- R7: A write to offset 13 performs a master clear. It zeroes the mode, command, terminal-count, software request and temporary registers, the byte pointer and the mode counter, and it sets all four masks. Address and count registers are left unchanged.
- R8: A write to offset 14 clears all four masks. A write to offset 15 loads mask i from data bit i.
- R9: Reads of offsets 9 and 15 return 0xF0 OR the request bits and 0xF0 OR the mask bits respectively (bit i = channel i). A read of offset 13 returns the temporary register, and a read of offset 10 returns 0xFF.
- R10: A read of offset 11 returns {mode of channel c, 2'b00}, where c is a 2-bit counter, and then increments c modulo 4. A read of offset 14 zeroes c.
- R11: Reset zeroes every base and current address and count register, and it also performs all master-clear actions of R7.
- R12: A write to offset 8 loads the command register. A cycle with temp_load high loads temp_data into the temporary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (one access per cycle) |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, zero otherwise |
| tc_in | input | 4 | Terminal-count pulses from the transfer engine |
| pend_in | input | 4 | Pending-request levels from the transfer engine |
| temp_load | input | 1 | Load strobe for the temporary register |
| temp_data | input | 8 | Temporary register data |
| ch_base_addr | output | 64 | Base addresses, channel i at bits 16i+15:16i |
| ch_cur_addr | output | 64 | Current addresses, same packing |
| ch_base_cnt | output | 64 | Base counts, same packing |
| ch_cur_cnt | output | 64 | Current counts, same packing |
| ch_mode | output | 24 | Mode fields, channel i at bits 6i+5:6i |
| ch_mask | output | 4 | Mask bit per channel |
| ch_swreq | output | 4 | Software request bit per channel |
| cmd_reg | output | 8 | Command register |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. The decoder does give the write priority if both are high. The assertions also assume that tc_in may pulse in any cycle, including the cycle of a status read. The stimulus drives every bus access as a single-cycle strobe with the other strobe low. It deliberately lines up one terminal-count pulse with a status read to exercise the clear-versus-set rule. It drives pend_in and temp_load only as levels or one-cycle pulses between bus accesses.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 6;

  localparam logic [3:0] OFS_CSR     = 4'd8;
  localparam logic [3:0] OFS_SWREQ   = 4'd9;
  localparam logic [3:0] OFS_MASK1   = 4'd10;
  localparam logic [3:0] OFS_MODE    = 4'd11;
  localparam logic [3:0] OFS_PTR     = 4'd12;
  localparam logic [3:0] OFS_MCLR    = 4'd13;
  localparam logic [3:0] OFS_MCLR_CT = 4'd14;
  localparam logic [3:0] OFS_MASKALL = 4'd15;

  typedef struct packed {
    logic            chan_wr;
    logic            chan_rd;
    logic [CH_W-1:0] chan_sel;
    logic            is_count;
    logic            status_rd;
    logic            cmd_wr;
    logic            req_wr;
    logic            mask_wr;
    logic            mode_wr;
    logic            mode_rd;
    logic            ptr_clr;
    logic            ptr_set;
    logic            mclr;
    logic            mask_clr_all;
    logic            mask_load_all;
    logic            cnt_clr;
  } bus_evt_t;

  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
    logic [REG_W-1:0] r;
    r = old;
    if (hi) r[REG_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                  input logic hi);
    return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] pad_nibble(input logic [NUM_CH-1:0] b);
    return {{(BYTE_W-NUM_CH){1'b1}}, b};
  endfunction
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic     [3:0] bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  output bus_evt_t       evt
);
  logic rd_q;
  assign rd_q = bus_rd & ~bus_wr;

  always_comb begin
    evt = '0;
    if (!bus_addr[3]) begin
      evt.chan_wr  = bus_wr;
      evt.chan_rd  = rd_q;
      evt.chan_sel = bus_addr[CH_W:1];
      evt.is_count = bus_addr[0];
    end else begin
      unique case (bus_addr)
        OFS_CSR:     begin evt.cmd_wr = bus_wr; evt.status_rd = rd_q; end
        OFS_SWREQ:   evt.req_wr = bus_wr;
        OFS_MASK1:   evt.mask_wr = bus_wr;
        OFS_MODE:    begin evt.mode_wr = bus_wr; evt.mode_rd = rd_q; end
        OFS_PTR:     begin evt.ptr_clr = bus_wr; evt.ptr_set = rd_q; end
        OFS_MCLR:    evt.mclr = bus_wr;
        OFS_MCLR_CT: begin evt.mask_clr_all = bus_wr; evt.cnt_clr = rd_q; end
        OFS_MASKALL: evt.mask_load_all = bus_wr;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NUM_CH-1:0] tc_in,
  input  logic              temp_load,
  input  logic [BYTE_W-1:0] temp_data,
  output logic              ptr_hi,
  output logic [CH_W-1:0]   mode_cnt,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] temp_q,
  output logic [NUM_CH-1:0] tc_q
);
  logic chan_access;
  assign chan_access = evt.chan_wr | evt.chan_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi   <= 1'b0;
      mode_cnt <= '0;
      cmd_q    <= '0;
      temp_q   <= '0;
      tc_q     <= '0;
    end else begin
      if (evt.mclr || evt.ptr_clr) ptr_hi <= 1'b0;
      else if (evt.ptr_set)        ptr_hi <= 1'b1;
      else if (chan_access)        ptr_hi <= ~ptr_hi;

      if (evt.mclr || evt.cnt_clr) mode_cnt <= '0;
      else if (evt.mode_rd)        mode_cnt <= mode_cnt + 1'b1;

      if (evt.mclr)        cmd_q <= '0;
      else if (evt.cmd_wr) cmd_q <= wdata;

      if (evt.mclr)         temp_q <= '0;
      else if (temp_load)   temp_q <= temp_data;

      if (evt.mclr)           tc_q <= '0;
      else if (evt.status_rd) tc_q <= tc_in;
      else                    tc_q <= tc_q | tc_in;
    end
  end

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_access |=> (ptr_hi != $past(ptr_hi)));
  // R3
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.status_rd |=> (tc_q == $past(tc_in)));
  // R3
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.status_rd && !evt.mclr) |=> ((tc_q & $past(tc_q)) == $past(tc_q)));
  // R10
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cnt_clr |=> (mode_cnt == '0));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ptr_hi,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [REG_W-1:0]  cur_cnt,
  output logic [MODE_W-1:0] mode,
  output logic              mask,
  output logic              req
);
  logic reg_hit, addr_wr, cnt_wr, chan_pick;
  assign reg_hit   = evt.chan_wr && (evt.chan_sel == CH_W'(CH));
  assign addr_wr   = reg_hit && !evt.is_count;
  assign cnt_wr    = reg_hit &&  evt.is_count;
  assign chan_pick = (wdata[CH_W-1:0] == CH_W'(CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (addr_wr) begin
        base_addr <= merge_byte(base_addr, wdata, ptr_hi);
        cur_addr  <= merge_byte(cur_addr,  wdata, ptr_hi);
      end
      if (cnt_wr) begin
        base_cnt <= merge_byte(base_cnt, wdata, ptr_hi);
        cur_cnt  <= merge_byte(cur_cnt,  wdata, ptr_hi);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      mask <= 1'b1;
      req  <= 1'b0;
    end else if (evt.mclr) begin
      mode <= '0;
      mask <= 1'b1;
      req  <= 1'b0;
    end else begin
      if (evt.mode_wr && chan_pick) mode <= wdata[BYTE_W-1:2];
      if (evt.req_wr && chan_pick)  req  <= wdata[2];
      if (evt.mask_clr_all)                mask <= 1'b0;
      else if (evt.mask_load_all)          mask <= wdata[CH];
      else if (evt.mask_wr && chan_pick)   mask <= wdata[2];
    end
  end

  // R7
  mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mclr |=> (mask && !req && mode == '0));
  // R7
  mclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mclr |=> ($stable(base_addr) && $stable(cur_addr) && $stable(base_cnt) && $stable(cur_cnt)));
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mask_load_all |=> (mask == $past(wdata[CH])));
  // R1
  base_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (pick_byte(base_addr, $past(ptr_hi)) == $past(wdata)));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  output logic [7:0]               bus_rdata,
  input  logic [3:0]               tc_in,
  input  logic [3:0]               pend_in,
  input  logic                     temp_load,
  input  logic [7:0]               temp_data,
  output logic [63:0]              ch_base_addr,
  output logic [63:0]              ch_cur_addr,
  output logic [63:0]              ch_base_cnt,
  output logic [63:0]              ch_cur_cnt,
  output logic [23:0]              ch_mode,
  output logic [3:0]               ch_mask,
  output logic [3:0]               ch_swreq,
  output logic [7:0]               cmd_reg
);
  bus_evt_t          evt;
  logic              ptr_hi;
  logic [CH_W-1:0]   mode_cnt;
  logic [BYTE_W-1:0] temp_q;
  logic [NUM_CH-1:0] tc_q;

  logic [REG_W-1:0]  base_addr_a [NUM_CH];
  logic [REG_W-1:0]  cur_addr_a  [NUM_CH];
  logic [REG_W-1:0]  base_cnt_a  [NUM_CH];
  logic [REG_W-1:0]  cur_cnt_a   [NUM_CH];
  logic [MODE_W-1:0] mode_a      [NUM_CH];

  dmac_decode u_decode (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .evt      (evt)
  );

  dmac_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wdata     (bus_wdata),
    .tc_in     (tc_in),
    .temp_load (temp_load),
    .temp_data (temp_data),
    .ptr_hi    (ptr_hi),
    .mode_cnt  (mode_cnt),
    .cmd_q     (cmd_reg),
    .temp_q    (temp_q),
    .tc_q      (tc_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dmac_chan #(.CH(c)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .wdata     (bus_wdata),
      .ptr_hi    (ptr_hi),
      .base_addr (base_addr_a[c]),
      .cur_addr  (cur_addr_a[c]),
      .base_cnt  (base_cnt_a[c]),
      .cur_cnt   (cur_cnt_a[c]),
      .mode      (mode_a[c]),
      .mask      (ch_mask[c]),
      .req       (ch_swreq[c])
    );
    assign ch_base_addr[c*REG_W +: REG_W] = base_addr_a[c];
    assign ch_cur_addr [c*REG_W +: REG_W] = cur_addr_a[c];
    assign ch_base_cnt [c*REG_W +: REG_W] = base_cnt_a[c];
    assign ch_cur_cnt  [c*REG_W +: REG_W] = cur_cnt_a[c];
    assign ch_mode     [c*MODE_W +: MODE_W] = mode_a[c];
  end

  logic rd_act;
  assign rd_act = bus_rd & ~bus_wr;

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      if (!bus_addr[3]) begin
        bus_rdata = bus_addr[0] ? pick_byte(cur_cnt_a[bus_addr[CH_W:1]], ptr_hi)
                                : pick_byte(cur_addr_a[bus_addr[CH_W:1]], ptr_hi);
      end else begin
        unique case (bus_addr)
          OFS_CSR:     bus_rdata = {pend_in, tc_q};
          OFS_SWREQ:   bus_rdata = pad_nibble(ch_swreq);
          OFS_MASK1:   bus_rdata = '1;
          OFS_MODE:    bus_rdata = {mode_a[mode_cnt], 2'b00};
          OFS_MCLR:    bus_rdata = temp_q;
          OFS_MASKALL: bus_rdata = pad_nibble(ch_mask);
          default:     bus_rdata = '0;
        endcase
      end
    end
  end

  // R12
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cmd_wr |=> (cmd_reg == $past(bus_wdata)));
  // R7
  mclr_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mclr |=> (cmd_reg == '0 && temp_q == '0 && tc_q == '0 && !ptr_hi));
  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_dmac_regfile.sv
module test_dmac_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  tc_in = '0;
  logic [3:0]  pend_in = '0;
  logic        temp_load = 1'b0;
  logic [7:0]  temp_data = '0;
  logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;
  logic [23:0] ch_mode;
  logic [3:0]  ch_mask, ch_swreq;
  logic [7:0]  cmd_reg;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  dmac_regfile i_dmac_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .tc_in(tc_in), .pend_in(pend_in), .temp_load(temp_load), .temp_data(temp_data),
    .ch_base_addr(ch_base_addr), .ch_cur_addr(ch_cur_addr),
    .ch_base_cnt(ch_base_cnt), .ch_cur_cnt(ch_cur_cnt), .ch_mode(ch_mode),
    .ch_mask(ch_mask), .ch_swreq(ch_swreq), .cmd_reg(cmd_reg)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] tc);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; tc_in = tc;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; tc_in = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_op(1'b0, 1'b1, a, d, 4'h0);
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); msk_q.push_back(8'hFF); tag_q.push_back(tag);
    bus_op(1'b1, 1'b0, a, 8'h00, 4'h0);
  endtask

  task automatic rd_any(input logic [3:0] a);
    exp_q.push_back(8'h00); msk_q.push_back(8'h00); tag_q.push_back("none");
    bus_op(1'b1, 1'b0, a, 8'h00, 4'h0);
  endtask

  task automatic pulse_tc(input logic [3:0] tc);
    @(negedge clk); tc_in = tc;
    @(negedge clk); tc_in = '0;
  endtask

  // Scoreboard monitor: pops one expected byte per read strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_rd && exp_q.size() > 0) begin
        logic [7:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        if (m != 8'h00) begin
          checks++;
          if ((bus_rdata & m) !== (e & m)) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 masks", ch_mask, 4'hF);
    check("R11 addr", ch_cur_addr, 64'h0);
    check("R11 cnt", ch_base_cnt, 64'h0);
    check("R11 cmd", cmd_reg, 8'h00);
    rd_exp(4'd15, 8'hFF, "R11 mask read");
    rd_exp(4'd9,  8'hF0, "R11 req read");
    rd_exp(4'd13, 8'h00, "R11 temp read");
    rd_exp(4'd10, 8'hFF, "R9 offset10");

    // R1 R2 channel register writes
    wr(4'd12, 8'h00);
    wr(4'd4, 8'h34); wr(4'd4, 8'h12);
    wr(4'd5, 8'hCD); wr(4'd5, 8'hAB);
    check("R1 ch2 cur addr", ch_cur_addr[47:32], 16'h1234);
    check("R1 ch2 base addr", ch_base_addr[47:32], 16'h1234);
    check("R1 ch2 cur cnt", ch_cur_cnt[47:32], 16'hABCD);
    check("R1 ch2 base cnt", ch_base_cnt[47:32], 16'hABCD);
    check("R1 ch1 untouched", ch_cur_cnt[31:16], 16'h0000);
    rd_exp(4'd4, 8'h34, "R2 low byte");
    rd_exp(4'd4, 8'h12, "R2 high byte");
    rd_exp(4'd5, 8'hCD, "R1 count low");
    rd_exp(4'd5, 8'hAB, "R1 count high");
    // R6 read of 12 sets pointer
    rd_any(4'd12);
    rd_exp(4'd4, 8'h12, "R6 ptr set by read");
    rd_exp(4'd4, 8'h34, "R2 toggle back");
    rd_any(4'd12);
    wr(4'd12, 8'h00);
    rd_exp(4'd4, 8'h34, "R6 ptr cleared by write");
    rd_any(4'd4);

    // R3 status
    pend_in = 4'b0100;
    pulse_tc(4'b1010);
    rd_exp(4'd8, 8'h4A, "R3 status");
    rd_exp(4'd8, 8'h40, "R3 cleared");
    pulse_tc(4'b0010);
    exp_q.push_back(8'h42); msk_q.push_back(8'hFF); tag_q.push_back("R3 clear vs set");
    bus_op(1'b1, 1'b0, 4'd8, 8'h00, 4'b0001);
    rd_exp(4'd8, 8'h41, "R3 new flag kept");
    pend_in = 4'b0000;
    rd_exp(4'd8, 8'h00, "R3 empty");

    // R4 R9 requests
    wr(4'd9, 8'b101);
    check("R4 req set", ch_swreq, 4'b0010);
    wr(4'd9, 8'b111);
    wr(4'd9, 8'b001);
    check("R4 req clr", ch_swreq, 4'b1000);
    rd_exp(4'd9, 8'hF8, "R9 req read");

    // R8 R4 masks
    wr(4'd14, 8'h00);
    check("R8 clear all", ch_mask, 4'h0);
    rd_exp(4'd15, 8'hF0, "R9 mask read");
    wr(4'd10, 8'b110);
    check("R4 mask single", ch_mask, 4'b0100);
    wr(4'd15, 8'h0B);
    check("R8 load all", ch_mask, 4'b1011);
    rd_exp(4'd15, 8'hFB, "R9 mask read2");
    wr(4'd10, 8'b000);
    check("R4 mask clr", ch_mask, 4'b1010);

    // R5 R10 mode
    wr(4'd11, 8'hA9);
    check("R5 ch1 mode", ch_mode[11:6], 6'h2A);
    wr(4'd11, 8'h57);
    check("R5 ch3 mode", ch_mode[23:18], 6'h15);
    check("R5 ch0 untouched", ch_mode[5:0], 6'h00);
    rd_any(4'd14);
    rd_exp(4'd11, 8'h00, "R10 ch0");
    rd_exp(4'd11, 8'hA8, "R10 ch1");
    rd_exp(4'd11, 8'h00, "R10 ch2");
    rd_exp(4'd11, 8'h54, "R10 ch3");
    rd_exp(4'd11, 8'h00, "R10 wrap");
    rd_exp(4'd11, 8'hA8, "R10 wrap ch1");
    rd_any(4'd14);
    rd_exp(4'd11, 8'h00, "R10 cleared ch0");
    rd_exp(4'd11, 8'hA8, "R10 cleared ch1");

    // R12 command and temp
    wr(4'd8, 8'h5A);
    check("R12 cmd", cmd_reg, 8'h5A);
    @(negedge clk); temp_load = 1'b1; temp_data = 8'h77;
    @(negedge clk); temp_load = 1'b0;
    rd_exp(4'd13, 8'h77, "R12 temp");

    // R7 master clear
    pulse_tc(4'b1000);
    rd_any(4'd12);
    wr(4'd13, 8'h00);
    check("R7 masks", ch_mask, 4'hF);
    check("R7 req", ch_swreq, 4'h0);
    check("R7 mode", ch_mode, 24'h0);
    check("R7 cmd", cmd_reg, 8'h00);
    check("R7 addr kept", ch_cur_addr[47:32], 16'h1234);
    check("R7 cnt kept", ch_base_cnt[47:32], 16'hABCD);
    rd_exp(4'd13, 8'h00, "R7 temp");
    rd_exp(4'd8, 8'h00, "R7 tc");
    rd_exp(4'd4, 8'h34, "R7 ptr clear");

    // R11 reset zeroes address and count
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 addr after reset", ch_cur_addr[47:32], 16'h0000);
    check("R11 base cnt after reset", ch_base_cnt[47:32], 16'h0000);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule